// File: doc/BRIEF.md
# Multi-stage expiry watchdog

This block is a memory-mapped watchdog that takes its time base from a companion tick generator. The tick generator divides the block clock, which runs from a fixed 1 MHz reference, into single-cycle tick pulses. The watchdog counts down a programmable number of those ticks. Each time the countdown runs out, that is one expiration. After the fourth expiration in a row with no service, the block raises a system-reset request.

Software configures the period and the enables, then starts the counter through a command register. It keeps the counter alive by writing the start command again. It can stop the counter only by first writing a magic key to a guard register.

A status register reports two values: the remaining countdown and the number of expirations seen since the last service. Software can combine them to work out how much time is left before the reset. All registers use a simple bus with byte addresses and one-cycle writes. Reads are combinational.

Top module: `wdog_top`

## Requirements
- R1: After reset, the config, status and tick-period registers read 0, and irq and rst_req are low.
- R2: The config register at offset 0x0 holds these fields: timer select in bits 3:0, expiration period in ticks in bits 11:4, interrupt enable in bit 12 and reset enable in bit 15. It reads back exactly what was written in those bits, and every other bit reads 0.
- R3: The tick-period register at offset 0x10 holds an enable flag in bit 31, a repeat flag in bit 30 and the period in clock cycles in bits 23:0, all readable. With enable and repeat both set, a tick occurs every period cycles, counted from the write. With repeat clear, one tick occurs and then the enable bit clears itself. With a period of 0 or enable clear, no ticks occur and the watchdog countdown freezes.
- R4: The status register at offset 0x4 reports the countdown in bits 11:4 and the expiration count in bits 13:12. Each tick lowers the countdown by one. A tick that would bring it to zero raises the expiration count by one and reloads the countdown from the period field.
- R5: Writing bit 0 of the command register at offset 0x8 starts the counter. A later write of bit 0 reloads the countdown from the period field and clears the expiration count.
- R6: When interrupt enable is set, irq is high for one cycle on each expiration. When it is clear, irq stays low.
- R7: With reset enable set, rst_req rises on the fourth expiration, with status then reading expiration count 3 and countdown 0. It does not rise on the first three expirations. Once high, it stays high until the block is reset, and a start command does not clear it.
- R8: With reset enable clear, the fourth expiration stops the counter with status reading expiration count 3 and countdown 0, and rst_req stays low.
- R9: A write of bit 1 to the command register stops the counter, so the countdown no longer changes. It does so only if the previous write to the guard register at offset 0xC was the value 0x0000C45A. Without that, the stop command is ignored and counting continues.
- R10: Any command-register write uses up an armed guard, whatever the write does. A guard write of any value other than the key leaves the guard unarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, fixed 1 MHz reference |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | One-cycle pulse per expiration |
| rst_req | output | 1 | Sticky system-reset request |

## Verification
The bench builds the block with its default parameters: a 5-bit address and a 24-bit tick period. Because the tick period is set at run time, the bench programs periods of one to four cycles and expiration periods of one to five ticks. That makes the fourth expiration, the stop on it, and keepalives landing on the same edge as a tick all reachable within tens of cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Register byte offsets
    localparam int OFS_CFG  = 'h0;
    localparam int OFS_STAT = 'h4;
    localparam int OFS_CMD  = 'h8;
    localparam int OFS_KEY  = 'hC;
    localparam int OFS_TMR  = 'h10;

    localparam logic [31:0] GUARD_KEY = 32'h0000_C45A;

    // Field positions
    localparam int CFG_SEL_LSB = 0;
    localparam int CFG_PER_LSB = 4;
    localparam int CFG_IRQ_BIT = 12;
    localparam int CFG_RST_BIT = 15;
    localparam int STS_CNT_LSB = 4;
    localparam int STS_EXP_LSB = 12;
    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_HALT_BIT = 1;
    localparam int TMR_EN_BIT  = 31;
    localparam int TMR_REP_BIT = 30;

    localparam int SEL_W = 4;
    localparam int CNT_W = 8;
    localparam int EXP_W = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [EXP_W-1:0] exp_t;

    typedef struct packed {
        logic             rst_en;
        logic             irq_en;
        cnt_t             period;
        logic [SEL_W-1:0] tmr_sel;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [31:0] w);
        cfg_t c;
        c.rst_en  = w[CFG_RST_BIT];
        c.irq_en  = w[CFG_IRQ_BIT];
        c.period  = w[CFG_PER_LSB +: CNT_W];
        c.tmr_sel = w[CFG_SEL_LSB +: SEL_W];
        return c;
    endfunction

    function automatic logic [31:0] cfg_pack(input cfg_t c);
        logic [31:0] w;
        w = '0;
        w[CFG_RST_BIT]            = c.rst_en;
        w[CFG_IRQ_BIT]            = c.irq_en;
        w[CFG_PER_LSB +: CNT_W]   = c.period;
        w[CFG_SEL_LSB +: SEL_W]   = c.tmr_sel;
        return w;
    endfunction

    function automatic logic [31:0] status_pack(input cnt_t cnt, input exp_t ex);
        logic [31:0] w;
        w = '0;
        w[STS_CNT_LSB +: CNT_W] = cnt;
        w[STS_EXP_LSB +: EXP_W] = ex;
        return w;
    endfunction

endpackage

// File: rtl/wdog_ticker.sv
module wdog_ticker #(
    parameter int TICK_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              en_in,
    input  logic              rep_in,
    input  logic [TICK_W-1:0] per_in,
    output logic              tick,
    output logic [31:0]       reg_q
);
    import wdog_pkg::*;

    localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

    logic              en_q;
    logic              rep_q;
    logic [TICK_W-1:0] per_q;
    logic [TICK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            rep_q <= 1'b0;
            per_q <= '0;
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (wr) begin
            en_q  <= en_in;
            rep_q <= rep_in;
            per_q <= per_in;
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (en_q && (per_q != '0)) begin
            if (cnt_q >= per_q - ONE) begin
                cnt_q <= '0;
                tick  <= 1'b1;
                if (!rep_q) en_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + ONE;
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    always_comb begin
        reg_q              = '0;
        reg_q[TMR_EN_BIT]  = en_q;
        reg_q[TMR_REP_BIT] = rep_q;
        reg_q[TICK_W-1:0]  = per_q;
    end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard (
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic        cmd_wr,
    input  logic [31:0] wdata,
    output logic        armed
);
    import wdog_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)         armed <= 1'b0;
        else if (cmd_wr) armed <= 1'b0;
        else if (key_wr) armed <= (wdata == GUARD_KEY);
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           go,
    input  logic           halt,
    input  wdog_pkg::cfg_t cfg,
    output logic           running,
    output wdog_pkg::cnt_t cnt,
    output wdog_pkg::exp_t ex,
    output logic           irq,
    output logic           rst_req
);
    import wdog_pkg::*;

    localparam exp_t EXP_LAST = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            ex      <= '0;
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (halt) begin
                running <= 1'b0;
            end else if (go) begin
                running <= 1'b1;
                cnt     <= cfg.period;
                ex      <= '0;
            end else if (running && tick) begin
                if (cnt <= cnt_t'(1)) begin
                    irq <= cfg.irq_en;
                    if (ex == EXP_LAST) begin
                        running <= 1'b0;
                        cnt     <= '0;
                        rst_req <= rst_req | cfg.rst_en;
                    end else begin
                        ex  <= ex + exp_t'(1);
                        cnt <= cfg.period;
                    end
                end else begin
                    cnt <= cnt - cnt_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int ADDR_W = 5,
    parameter int TICK_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    import wdog_pkg::*;

    logic sel_cfg, sel_stat, sel_cmd, sel_key, sel_tmr;
    logic cfg_wr, cmd_wr, key_wr, tmr_wr;
    logic tick, armed, running, go, halt;
    cfg_t cfg_q;
    cnt_t cnt;
    exp_t ex;
    logic [31:0] tmr_q;

    assign sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
    assign sel_key  = (bus_addr == ADDR_W'(OFS_KEY));
    assign sel_tmr  = (bus_addr == ADDR_W'(OFS_TMR));

    assign cfg_wr = bus_we && sel_cfg;
    assign cmd_wr = bus_we && sel_cmd;
    assign key_wr = bus_we && sel_key;
    assign tmr_wr = bus_we && sel_tmr;

    assign halt = cmd_wr && bus_wdata[CMD_HALT_BIT] && armed;
    assign go   = cmd_wr && bus_wdata[CMD_GO_BIT];

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_unpack(bus_wdata);
    end

    wdog_ticker #(.TICK_W(TICK_W)) u_ticker (
        .clk    (clk),
        .rst    (rst),
        .wr     (tmr_wr),
        .en_in  (bus_wdata[TMR_EN_BIT]),
        .rep_in (bus_wdata[TMR_REP_BIT]),
        .per_in (bus_wdata[TICK_W-1:0]),
        .tick   (tick),
        .reg_q  (tmr_q)
    );

    wdog_guard u_guard (
        .clk    (clk),
        .rst    (rst),
        .key_wr (key_wr),
        .cmd_wr (cmd_wr),
        .wdata  (bus_wdata),
        .armed  (armed)
    );

    wdog_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .go      (go),
        .halt    (halt),
        .cfg     (cfg_q),
        .running (running),
        .cnt     (cnt),
        .ex      (ex),
        .irq     (irq),
        .rst_req (rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg)       bus_rdata = cfg_pack(cfg_q);
        else if (sel_stat) bus_rdata = status_pack(cnt, ex);
        else if (sel_tmr)  bus_rdata = tmr_q;
    end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic           cmd_wr,
    input logic           halt_bit,
    input logic           armed,
    input logic           running,
    input wdog_pkg::cnt_t cnt,
    input wdog_pkg::exp_t ex,
    input logic           irq,
    input logic           rst_req
);
    AST_FROZEN_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cmd_wr) |=> ($stable(cnt) && $stable(ex))); // R4
    AST_IRQ_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(tick)); // R6
    AST_RST_STICKY: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req); // R7
    AST_RST_ON_LAST_EXP: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> (ex == '1 && !running && cnt == '0)); // R7
    AST_LOCKED_HALT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && halt_bit && !armed && running && !tick) |=> running); // R9
    AST_UNLOCKED_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && halt_bit && armed) |=> !running); // R9
    AST_GUARD_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !armed); // R10
endmodule

bind wdog_top wdog_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmd_wr   (cmd_wr),
    .halt_bit (bus_wdata[1]),
    .armed    (armed),
    .running  (running),
    .cnt      (cnt),
    .ex       (ex),
    .irq      (irq),
    .rst_req  (rst_req)
);

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_CFG = 5'h00, A_STAT = 5'h04, A_CMD = 5'h08,
                                  A_KEY = 5'h0C, A_TMR = 5'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, rst_req;

    int cyc = 0;
    int irq_seen = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    wdog_top u_wdog_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (irq) irq_seen <= irq_seen + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output int e);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        e = cyc;
    endtask

    task automatic wrn(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        int e;
        wr(a, d, e);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
    endtask

    // ticks applied to the counter up to and including edge x, timer written at edge w
    function automatic int nt(input int w, input int p, input int x);
        return (x > w) ? (x - w - 1) / p : 0;
    endfunction

    function automatic logic [31:0] stat_exp(input int t, input int k);
        if (t >= 4 * k) return 32'h0000_3000;
        return 32'((t / k) << 12) | 32'((k - t % k) << 4);
    endfunction

    function automatic int exp_cnt(input int t, input int k);
        return (t / k > 4) ? 4 : t / k;
    endfunction

    task automatic moving(output logic m);
        logic [31:0] a, b;
        rd(A_STAT, a);
        wait_n(3);
        rd(A_STAT, b);
        m = (a != b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v;
        logic m;
        int w, s, c, base;
        v = $urandom(32'h5EED_0042);
        wait_n(3);
        rst = 1'b0;

        // R1 reset state
        rd(A_CFG, d);  chk("R1 cfg after reset", d, 0);
        rd(A_STAT, d); chk("R1 status after reset", d, 0);
        rd(A_TMR, d);  chk("R1 timer after reset", d, 0);
        chk("R1 irq/rst_req after reset", {30'd0, irq, rst_req}, 0);

        // R2 config fields
        wrn(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, d); chk("R2 cfg all ones", d, 32'h0000_9FFF);
        for (int i = 0; i < 4; i++) begin
            v = $urandom;
            wrn(A_CFG, v);
            rd(A_CFG, d); chk("R2 cfg random", d, v & 32'h0000_9FFF);
        end

        // R3 timer register and one-shot
        wrn(A_TMR, 32'hFFFF_FFFF);
        rd(A_TMR, d); chk("R3 timer readback", d, 32'hC0FF_FFFF);
        wrn(A_TMR, 32'h8000_0003);
        wait_n(5);
        rd(A_TMR, d); chk("R3 one-shot self-clears enable", d, 32'h0000_0003);

        // R4/R5/R6/R8 random runs
        for (int it = 0; it < 24; it++) begin
            int p, k, ie, ka, t1;
            p  = 1 + int'($urandom % 4);
            k  = 1 + int'($urandom % 5);
            ie = int'($urandom % 2);
            ka = int'($urandom % 2);
            wrn(A_TMR, 0);
            wrn(A_CFG, 32'(k << 4) | 32'(ie << 12) | 32'd5);
            wrn(A_CMD, 1);
            wr(A_TMR, 32'hC000_0000 | 32'(p), w);
            base = irq_seen;
            wait_n(1 + int'($urandom % (5 * k * p + 4)));
            if (ka != 0) begin
                wr(A_CMD, 1, s);
                t1 = nt(w, p, s - 1);
                wait_n(1 + int'($urandom % (5 * k * p + 4)));
                c = cyc;
                rd(A_STAT, d);
                chk("R5 status after keepalive", d, stat_exp(nt(w, p, c) - nt(w, p, s), k));
                chk("R6 irq pulses with keepalive", 32'(irq_seen - base),
                    (ie != 0) ? 32'(exp_cnt(t1, k) + exp_cnt(nt(w, p, c) - nt(w, p, s), k)) : 0);
            end else begin
                c = cyc;
                rd(A_STAT, d);
                chk("R4 status countdown", d, stat_exp(nt(w, p, c), k));
                chk("R6 irq pulses", 32'(irq_seen - base),
                    (ie != 0) ? 32'(exp_cnt(nt(w, p, c), k)) : 0);
            end
            chk("R8 no reset with reset enable clear", {31'd0, rst_req}, 0);
        end

        // R9 / R10 guard behaviour
        wrn(A_TMR, 0);
        wrn(A_CFG, 32'd200 << 4);
        wrn(A_CMD, 1);
        wrn(A_TMR, 32'hC000_0001);
        wrn(A_CMD, 2);
        moving(m); chk("R9 locked halt ignored", {31'd0, m}, 1);
        wrn(A_KEY, 32'h0000_1234);
        wrn(A_CMD, 2);
        moving(m); chk("R10 wrong key does not arm", {31'd0, m}, 1);
        wrn(A_KEY, 32'h0000_C45A);
        wrn(A_CMD, 1);
        wrn(A_CMD, 2);
        moving(m); chk("R10 guard consumed by start write", {31'd0, m}, 1);
        wrn(A_KEY, 32'h0000_C45A);
        wrn(A_CMD, 2);
        moving(m); chk("R9 unlocked halt stops", {31'd0, m}, 0);

        // R3 freeze via timer
        wrn(A_CMD, 1);
        moving(m); chk("R3 restarted counter moves", {31'd0, m}, 1);
        wrn(A_TMR, 0);
        moving(m); chk("R3 zero timer freezes", {31'd0, m}, 0);
        wrn(A_TMR, 32'h8000_0000);
        moving(m); chk("R3 enabled zero period freezes", {31'd0, m}, 0);

        // R7 reset request on fourth expiration
        do_reset();
        wrn(A_CFG, (32'd2 << 4) | (32'd1 << 12) | (32'd1 << 15));
        wrn(A_CMD, 1);
        wr(A_TMR, 32'hC000_0001, w);
        base = irq_seen;
        wait_n(8);
        rd(A_STAT, d); chk("R7 status before fourth", d, 32'h0000_3010);
        chk("R7 no reset before fourth", {31'd0, rst_req}, 0);
        wait_n(1);
        rd(A_STAT, d); chk("R7 status at fourth", d, 32'h0000_3000);
        chk("R7 reset on fourth", {31'd0, rst_req}, 1);
        chk("R6 four irq pulses", 32'(irq_seen - base), 4);
        wrn(A_CMD, 1);
        wait_n(2);
        chk("R7 reset sticky over start", {31'd0, rst_req}, 1);
        do_reset();
        chk("R1 reset clears rst_req", {31'd0, rst_req}, 0);

        // R8 fourth expiration without reset enable
        wrn(A_CFG, 32'd2 << 4);
        wrn(A_CMD, 1);
        wrn(A_TMR, 32'hC000_0001);
        base = irq_seen;
        wait_n(19);
        rd(A_STAT, d); chk("R8 stopped at fourth", d, 32'h0000_3000);
        chk("R8 no reset request", {31'd0, rst_req}, 0);
        chk("R6 no irq when disabled", 32'(irq_seen - base), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule